// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block turns the serial output of a UART into the return-to-zero pulse train used by slow infrared links. It runs on a fast system clock. A one-cycle strobe, `tick16`, marks each period of the 16x baud clock, so every bit spans sixteen strobes. For each space (0) bit on the transmit line the block emits one short high pulse, placed seven strobes into the bit. A mark (1) bit produces no pulse, so the output stays low.

A falling edge on the synchronized transmit line sets a bit-phase counter to zero. While the line stays low, the counter keeps cycling through sixteen strobes, so a run of zero bits gives evenly spaced pulses without any new edge. The width-select input picks the pulse width:

- **Low:** three strobes, which is 3/16 of a bit.
- **High:** a fixed number of system-clock cycles (about 1.6 µs by default). This width is cut short so that it never runs into the next bit's pulse.

The high setting is the default, so a board that leaves the select undriven should tie it high.

Top module: `irda_sir_encoder`

## Requirements
- R1: While `rst_n` is low, and after reset until the first pulse, `ir_out` is low. Asserting `rst_n` during a pulse drives `ir_out` low at once.
- R2: A transmit bit that is 0 (space) yields exactly one pulse, and a bit that is 1 (mark) yields none. A line held high yields no pulse.
- R3: `txd` passes through two synchronizer flops. Take the first clock edge that samples a new low level on `txd` as edge k. The pulse then rises on the seventh `tick16` edge strictly after edge k+2.
- R4: With `width_sel` = 0, the pulse stays high for exactly 3 `tick16` periods.
- R5: With `width_sel` = 1, the pulse stays high for exactly `FIXED_CYCLES` system clocks, provided that is shorter than 15 `tick16` periods.
- R6: In a run of consecutive zero bits, successive pulses rise exactly 16 `tick16` periods apart.
- R7: In fixed-width mode the pulse is clamped to at most 15 `tick16` periods, which keeps pulses of adjacent zero bits separate.
- R8: Every falling edge of `txd` realigns the bit phase. The pulse after an edge that falls off the previous 16-strobe grid still follows the R3 timing from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously by the system |
| tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| txd | input | 1 | UART transmit line, idle high |
| width_sel | input | 1 | 0: 3/16-bit pulse, 1: fixed-time pulse (default setting) |
| ir_out | output | 1 | Infrared pulse output, active high |

## Verification
The assertions check four things on every clock:
- a pulse rises only at the bit phase that follows the start offset;
- the output is high only while a zero-bit run is being tracked;
- a short pulse never outlasts three strobes;
- a fixed pulse never outlasts its cycle count or the 15-strobe clamp.

Some behaviour can only be shown by the bench scenarios, each measured at the ports:
- exact widths, the offset from the line edge, and the 16-strobe spacing;
- that mark bits are silent;
- realignment on an off-grid edge;
- clearing by reset in the middle of a pulse.

A behavioural model compared on every clock covers the remaining cycle-level detail.

// File: rtl/irda_pkg.sv
package irda_pkg;
  typedef enum logic {
    WIDTH_SHORT = 1'b0,
    WIDTH_FIXED = 1'b1
  } width_mode_e;
endpackage

// File: rtl/irda_tx_sync.sv
// Two-flop synchronizer on the transmit line plus falling-edge detect.
module irda_tx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  output logic line,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= txd;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign line = s2_q;
  assign fall = prev_q & ~s2_q;
endmodule

// File: rtl/irda_bit_phase.sv
// Bit-phase counter in 16x strobes, realigned on each falling edge.
module irda_bit_phase #(
  parameter int TICKS      = 16,
  parameter int START_TICK = 7,
  localparam int PW        = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fall,
  input  logic          line,
  output logic [PW-1:0] phase,
  output logic          run,
  output logic          start,
  output logic          clamp
);
  localparam int DECIDE_IDX = START_TICK - 1;
  localparam int CLAMP_IDX  = (START_TICK + TICKS - 2) % TICKS;

  logic [PW-1:0] phase_q, phase_n;
  logic          run_q, run_n;
  logic          at_decide;

  assign at_decide = (phase_q == PW'(DECIDE_IDX));

  always_comb begin
    phase_n = phase_q;
    run_n   = run_q;
    if (fall) begin
      phase_n = '0;
      run_n   = 1'b1;
    end else if (tick) begin
      phase_n = (phase_q == PW'(TICKS - 1)) ? '0 : phase_q + 1'b1;
      if (run_q && at_decide && line) run_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      run_q   <= run_n;
    end
  end

  assign phase = phase_q;
  assign run   = run_q;
  assign start = tick & run_q & ~fall & ~line & at_decide;
  assign clamp = tick & (phase_q == PW'(CLAMP_IDX));
endmodule

// File: rtl/irda_pulse_timer.sv
// Times the pulse: SHORT_TICKS strobes, or FIXED_CYCLES clocks clamped by phase.
module irda_pulse_timer
  import irda_pkg::*;
#(
  parameter int SHORT_TICKS  = 3,
  parameter int FIXED_CYCLES = 160,
  localparam int MAXC        = (FIXED_CYCLES > SHORT_TICKS) ? FIXED_CYCLES : SHORT_TICKS,
  localparam int CW          = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fall,
  input  logic start,
  input  logic clamp,
  input  logic width_sel,
  output logic pulse,
  output logic fixed_mode
);
  logic          out_q, out_n;
  logic [CW-1:0] cnt_q, cnt_n;
  width_mode_e   mode_q, mode_n;

  always_comb begin
    out_n  = out_q;
    cnt_n  = cnt_q;
    mode_n = mode_q;
    if (fall) begin
      out_n = 1'b0;
    end else if (start) begin
      out_n  = 1'b1;
      cnt_n  = '0;
      mode_n = width_sel ? WIDTH_FIXED : WIDTH_SHORT;
    end else if (out_q) begin
      if (clamp) begin
        out_n = 1'b0;
      end else if (mode_q == WIDTH_FIXED) begin
        if (cnt_q == CW'(FIXED_CYCLES - 1)) out_n = 1'b0;
        else                                cnt_n = cnt_q + 1'b1;
      end else if (tick) begin
        if (cnt_q == CW'(SHORT_TICKS - 1)) out_n = 1'b0;
        else                               cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      cnt_q  <= '0;
      mode_q <= WIDTH_SHORT;
    end else begin
      out_q  <= out_n;
      cnt_q  <= cnt_n;
      mode_q <= mode_n;
    end
  end

  assign pulse      = out_q;
  assign fixed_mode = (mode_q == WIDTH_FIXED);
endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder #(
  parameter int TICKS        = 16,
  parameter int START_TICK   = 7,
  parameter int SHORT_TICKS  = 3,
  parameter int FIXED_CYCLES = 160,
  localparam int PW          = $clog2(TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic txd,
  input  logic width_sel,
  output logic ir_out
);
  logic          line_w, fall_w, run_w, start_w, clamp_w, fixed_w;
  logic [PW-1:0] phase_w;

  irda_tx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .txd(txd), .line(line_w), .fall(fall_w)
  );

  irda_bit_phase #(.TICKS(TICKS), .START_TICK(START_TICK)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fall(fall_w), .line(line_w),
    .phase(phase_w), .run(run_w), .start(start_w), .clamp(clamp_w)
  );

  irda_pulse_timer #(.SHORT_TICKS(SHORT_TICKS), .FIXED_CYCLES(FIXED_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .fall(fall_w), .start(start_w),
    .clamp(clamp_w), .width_sel(width_sel), .pulse(ir_out), .fixed_mode(fixed_w)
  );
endmodule

// File: rtl/irda_sir_encoder_chk.sv
module irda_sir_encoder_chk #(
  parameter int TICKS        = 16,
  parameter int START_TICK   = 7,
  parameter int SHORT_TICKS  = 3,
  parameter int FIXED_CYCLES = 160,
  localparam int PW          = $clog2(TICKS),
  localparam int HW          = $clog2(TICKS + 1),
  localparam int FW          = $clog2(FIXED_CYCLES + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          out,
  input logic          run,
  input logic          fixed,
  input logic [PW-1:0] phase
);
  logic [HW-1:0] hi_ticks;
  logic [FW-1:0] hi_clks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks <= '0;
      hi_clks  <= '0;
    end else begin
      hi_ticks <= out ? (tick ? hi_ticks + 1'b1 : hi_ticks) : '0;
      hi_clks  <= out ? hi_clks + 1'b1 : '0;
    end
  end

  // R3: a pulse rises only at the start phase of its bit
  a_r3_rise_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out) |-> (phase == PW'(START_TICK)));

  // R2: output high only while a zero-bit run is tracked
  a_r2_out_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> run);

  // R4: short pulses never exceed SHORT_TICKS strobes
  a_r4_short_width: assert property (@(posedge clk) disable iff (!rst_n)
    (out && !fixed) |-> (hi_ticks <= HW'(SHORT_TICKS - 1)));

  // R5: fixed pulses never exceed FIXED_CYCLES clocks
  a_r5_fixed_width: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> (hi_clks <= FW'(FIXED_CYCLES - 1)));

  // R7: any pulse stays within 15 strobes of a bit
  a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> (hi_ticks <= HW'(TICKS - 2)));
endmodule

bind irda_sir_encoder irda_sir_encoder_chk #(
  .TICKS(TICKS), .START_TICK(START_TICK),
  .SHORT_TICKS(SHORT_TICKS), .FIXED_CYCLES(FIXED_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick16), .out(ir_out),
  .run(run_w), .fixed(fixed_w), .phase(phase_w)
);

// File: tb/test_irda_sir_encoder.sv
module test_irda_sir_encoder;
  localparam int FIXED = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic txd = 1'b1;
  logic width_sel = 1'b0;
  logic ir_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv = 8;
  int divcnt = 0;
  bit done = 1'b0;

  int rises[$];
  int fallo[$];
  int edges[$];
  bit last_out = 1'b0;

  // behavioural model state
  int m_s1 = 1, m_s2 = 1, m_pv = 1, m_ph = 0, m_run = 0, m_out = 0, m_cnt = 0, m_fx = 0;

  irda_sir_encoder i_irda_sir_encoder (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .txd(txd),
    .width_sel(width_sel), .ir_out(ir_out)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick16 <= (divcnt == 0);
    divcnt <= (divcnt + 1 >= tdiv) ? 0 : divcnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // model advance and per-clock compare
  always @(posedge clk) begin
    int fall, start, clampv, nph, nrun, nout, ncnt, nfx;
    cyc++;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_pv = 1; m_ph = 0; m_run = 0; m_out = 0; m_cnt = 0; m_fx = 0;
    end else begin
      fall   = (m_pv == 1 && m_s2 == 0);
      start  = tick16 && m_run && !fall && m_s2 == 0 && m_ph == 6;
      clampv = tick16 && m_ph == 5;
      nph = m_ph; nrun = m_run; nout = m_out; ncnt = m_cnt; nfx = m_fx;
      if (fall) begin
        nph = 0; nrun = 1;
      end else if (tick16) begin
        nph = (m_ph + 1) % 16;
        if (m_run && m_ph == 6 && m_s2 == 1) nrun = 0;
      end
      if (fall) nout = 0;
      else if (start) begin nout = 1; ncnt = 0; nfx = width_sel; end
      else if (m_out) begin
        if (clampv) nout = 0;
        else if (m_fx) begin
          if (m_cnt == FIXED - 1) nout = 0; else ncnt = m_cnt + 1;
        end else if (tick16) begin
          if (m_cnt == 2) nout = 0; else ncnt = m_cnt + 1;
        end
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = txd;
      m_ph = nph; m_run = nrun; m_out = nout; m_cnt = ncnt; m_fx = nfx;
    end
    #2;
    if (!done) chk("R3 model", int'(ir_out), m_out);
    if (ir_out && !last_out) rises.push_back(cyc);
    if (!ir_out && last_out) fallo.push_back(cyc);
    last_out = ir_out;
  end

  task automatic wait_clks(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic send_bit(bit b, int nticks);
    @(negedge clk);
    if (!b && txd) edges.push_back(cyc);
    txd = b;
    wait_clks(nticks * tdiv);
  endtask

  task automatic clear_q();
    rises.delete(); fallo.delete(); edges.delete();
  endtask

  task automatic chk_offset(string req, int rise, int drv);
    int k = drv + 1;
    chk_rng(req, rise, k + 3 + 6 * tdiv, k + 2 + 7 * tdiv);
  endtask

  initial begin
    wait_clks(4);
    chk("R1 reset low", int'(ir_out), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_clks(20);
    chk("R1 idle low", int'(ir_out), 0);

    // short width, run of zeros, mark, zero
    tdiv = 8; width_sel = 1'b0;
    wait_clks(32);
    clear_q();
    send_bit(0, 16); send_bit(0, 16); send_bit(0, 16);
    send_bit(1, 16); send_bit(0, 16); send_bit(1, 40);
    chk("R2 pulses per space", rises.size(), 4);
    chk("R2 falls", fallo.size(), 4);
    for (int i = 0; i < rises.size() && i < fallo.size(); i++)
      chk("R4 short width", fallo[i] - rises[i], 3 * 8);
    if (rises.size() >= 3) begin
      chk("R6 spacing", rises[1] - rises[0], 16 * 8);
      chk("R6 spacing", rises[2] - rises[1], 16 * 8);
    end
    if (rises.size() >= 4 && edges.size() >= 2) begin
      chk_offset("R3 offset", rises[0], edges[0]);
      chk_offset("R3 offset", rises[3], edges[1]);
    end

    // fixed width, bit longer than fixed time
    tdiv = 20; width_sel = 1'b1;
    wait_clks(60);
    clear_q();
    send_bit(0, 16); send_bit(1, 16); send_bit(0, 16); send_bit(1, 30);
    chk("R2 fixed pulses", rises.size(), 2);
    for (int i = 0; i < rises.size() && i < fallo.size(); i++)
      chk("R5 fixed width", fallo[i] - rises[i], FIXED);

    // fixed width clamped by short bit
    tdiv = 8;
    wait_clks(40);
    clear_q();
    send_bit(0, 16); send_bit(0, 16); send_bit(1, 40);
    chk("R7 clamped pulses", rises.size(), 2);
    for (int i = 0; i < rises.size() && i < fallo.size(); i++)
      chk("R7 clamp width", fallo[i] - rises[i], 15 * 8);
    if (rises.size() >= 2) chk("R6 clamped spacing", rises[1] - rises[0], 128);

    // realign on an off-grid edge
    width_sel = 1'b0;
    wait_clks(40);
    clear_q();
    send_bit(0, 16); send_bit(1, 5); send_bit(0, 16); send_bit(1, 40);
    chk("R8 pulses", rises.size(), 2);
    if (rises.size() >= 2 && edges.size() >= 2) chk_offset("R8 realign", rises[1], edges[1]);

    // mark idle
    clear_q();
    send_bit(1, 16 * 20);
    chk("R2 mark silent", rises.size(), 0);

    // reset during a pulse
    tdiv = 20; width_sel = 1'b1;
    wait_clks(40);
    send_bit(0, 9);
    chk("R1 pulse active before reset", int'(ir_out), 1);
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1 reset clears pulse", int'(ir_out), 0);
    txd = 1'b1;
    wait_clks(3);
    chk("R1 held in reset", int'(ir_out), 0);
    @(negedge clk) rst_n = 1'b1;
    wait_clks(10);
    chk("R1 low after release", int'(ir_out), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule